// File: doc/BRIEF.md
# Byte Block Bit-Plane Transposer with Character Class Markers

This block takes a block of byte characters every valid cycle and turns it into eight bit-plane vectors. Plane k carries bit k of every byte, with bit 0 taken as the most significant bit of the byte. From those planes alone, a small net of shared AND, OR and AND-NOT terms produces one marker bit per byte position for four fixed character classes: the less-than sign, the greater-than sign, the ASCII decimal digits, and the control characters 0x00 to 0x1F.

All outputs come from one register stage and are therefore aligned with each other. Bit i of every output vector belongs to byte i of the input block, where byte 0 is the first byte. A downstream stage can then treat each vector as a little-endian stream of positions and use shifts, additions and masks on it to scan for markup without looking at single bytes.

Top module: `byte_plane_classifier`

## Requirements
- R1: Byte i of the block occupies in_bytes[8i+7:8i]. Plane k occupies out_planes[k*BYTES +: BYTES], and its bit i equals in_bytes[8i+7-k]. Plane 0 is therefore the most significant bit of each byte.
- R2: A block presented with in_valid high at a rising edge appears on all data outputs right after that edge, and out_valid is high for exactly that one cycle.
- R3: A cycle with in_valid low drives out_valid low after the edge. In that cycle all plane and marker outputs keep their previous values, whatever in_bytes carries.
- R4: A synchronous active-high reset clears out_valid, every plane and every marker to zero, and it takes priority over in_valid.
- R5: out_lt bit i is 1 exactly when byte i equals 0x3C.
- R6: out_gt bit i is 1 exactly when byte i equals 0x3E.
- R7: out_digit bit i is 1 exactly when byte i lies in 0x30 to 0x39.
- R8: out_ctrl bit i is 1 exactly when byte i lies in 0x00 to 0x1F. Bytes 0x80 and above never set it.
- R9: Each position's planes and markers depend only on that position's own byte. The first and the last position behave the same as all the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_bytes holds a block to convert |
| in_bytes | input | 8*BYTES | Byte block, byte i at bits 8i+7..8i |
| out_valid | output | 1 | Outputs were loaded at the last edge |
| out_planes | output | 8*BYTES | Eight bit planes, plane k at k*BYTES |
| out_lt | output | BYTES | Less-than marker per position |
| out_gt | output | BYTES | Greater-than marker per position |
| out_digit | output | BYTES | Decimal digit marker per position |
| out_ctrl | output | BYTES | Control character marker per position |

## Verification
The block holds no state other than its single output register. A wrong plane tap or a wrong class term therefore shows as a wrong bit at one position, in the cycle right after the block is loaded. A load enable that is wrongly wired shows as outputs that change, or fail to hold, in the cycle after an idle input. The bench sweeps all 256 byte values through every position group and compares each marker against a plain byte-compare reference. Directed blocks place each class boundary value (0x2F, 0x3A, 0x1F, 0x20, 0xBC and others) in all positions, so a mismatch shows on the first output after the faulty block.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int BYTE_W      = 8;
  localparam int NUM_PLANES  = BYTE_W;
  localparam int NUM_CLASSES = 4;

  // index of each class vector inside the packed marker bundle
  typedef enum int {
    CLS_LT    = 0,
    CLS_GT    = 1,
    CLS_DIGIT = 2,
    CLS_CTRL  = 3
  } class_idx_e;
endpackage

// File: rtl/bpc_transpose.sv
module bpc_transpose
  import bpc_pkg::*;
#(
  parameter int BYTES = 16
) (
  input  logic [BYTES*BYTE_W-1:0]                bytes_i,
  output logic [NUM_PLANES-1:0][BYTES-1:0]       planes_o
);
  // plane 0 taps the most significant bit of each byte
  for (genvar k = 0; k < NUM_PLANES; k++) begin : g_plane
    for (genvar i = 0; i < BYTES; i++) begin : g_pos
      assign planes_o[k][i] = bytes_i[i*BYTE_W + (BYTE_W-1-k)];
    end
  end
endmodule

// File: rtl/bpc_classes.sv
module bpc_classes
  import bpc_pkg::*;
#(
  parameter int BYTES = 16
) (
  input  logic [NUM_PLANES-1:0][BYTES-1:0]  planes_i,
  output logic [NUM_CLASSES-1:0][BYTES-1:0] marks_o
);
  logic [BYTES-1:0] p0, p1, p2, p3, p4, p5, p6, p7;
  logic [BYTES-1:0] hi_clear;   // top two bits zero
  logic [BYTES-1:0] mid_set;    // bits 2 and 3 set
  logic [BYTES-1:0] row_3x;     // byte in 0x30..0x3F
  logic [BYTES-1:0] lo_c;       // bits 4 and 5 set
  logic [BYTES-1:0] tail_00;    // last two bits 00
  logic [BYTES-1:0] tail_10;    // last two bits 10
  logic [BYTES-1:0] over_9;     // low nibble above 9

  assign p0 = planes_i[0];
  assign p1 = planes_i[1];
  assign p2 = planes_i[2];
  assign p3 = planes_i[3];
  assign p4 = planes_i[4];
  assign p5 = planes_i[5];
  assign p6 = planes_i[6];
  assign p7 = planes_i[7];

  // terms shared across the classes
  assign hi_clear = ~(p0 | p1);
  assign mid_set  = p2 & p3;
  assign row_3x   = mid_set & hi_clear;
  assign lo_c     = p4 & p5;
  assign tail_00  = ~(p6 | p7);
  assign tail_10  = p6 & ~p7;
  assign over_9   = p4 & (p5 | p6);

  assign marks_o[CLS_LT]    = row_3x & lo_c & tail_00;
  assign marks_o[CLS_GT]    = row_3x & lo_c & tail_10;
  assign marks_o[CLS_DIGIT] = row_3x & ~over_9;
  assign marks_o[CLS_CTRL]  = hi_clear & ~p2;
endmodule

// File: rtl/bpc_outreg.sv
module bpc_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/byte_plane_classifier.sv
module byte_plane_classifier
  import bpc_pkg::*;
#(
  parameter int BYTES = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [BYTES*BYTE_W-1:0]   in_bytes,
  output logic                      out_valid,
  output logic [NUM_PLANES*BYTES-1:0] out_planes,
  output logic [BYTES-1:0]          out_lt,
  output logic [BYTES-1:0]          out_gt,
  output logic [BYTES-1:0]          out_digit,
  output logic [BYTES-1:0]          out_ctrl
);
  localparam int PLANE_BITS = NUM_PLANES * BYTES;
  localparam int MARK_BITS  = NUM_CLASSES * BYTES;
  localparam int DATA_BITS  = PLANE_BITS + MARK_BITS;

  logic [NUM_PLANES-1:0][BYTES-1:0]  planes;
  logic [NUM_CLASSES-1:0][BYTES-1:0] marks;
  logic [DATA_BITS-1:0]              data_d, data_q;
  logic [0:0]                        vld_q;

  bpc_transpose #(.BYTES(BYTES)) u_transpose (
    .bytes_i  (in_bytes),
    .planes_o (planes)
  );

  bpc_classes #(.BYTES(BYTES)) u_classes (
    .planes_i (planes),
    .marks_o  (marks)
  );

  assign data_d = {marks, planes};

  bpc_outreg #(.W(DATA_BITS)) u_data_reg (
    .clk (clk),
    .rst (rst),
    .en  (in_valid),
    .d   (data_d),
    .q   (data_q)
  );

  bpc_outreg #(.W(1)) u_valid_reg (
    .clk (clk),
    .rst (rst),
    .en  (1'b1),
    .d   (in_valid),
    .q   (vld_q)
  );

  assign out_valid  = vld_q[0];
  assign out_planes = data_q[PLANE_BITS-1:0];
  assign out_lt     = data_q[PLANE_BITS + CLS_LT*BYTES    +: BYTES];
  assign out_gt     = data_q[PLANE_BITS + CLS_GT*BYTES    +: BYTES];
  assign out_digit  = data_q[PLANE_BITS + CLS_DIGIT*BYTES +: BYTES];
  assign out_ctrl   = data_q[PLANE_BITS + CLS_CTRL*BYTES  +: BYTES];
endmodule

// File: rtl/byte_plane_classifier_checker.sv
module byte_plane_classifier_checker #(
  parameter int BYTES = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [BYTES*8-1:0]   in_bytes,
  input logic                 out_valid,
  input logic [8*BYTES-1:0]   out_planes,
  input logic [BYTES-1:0]     out_lt,
  input logic [BYTES-1:0]     out_gt,
  input logic [BYTES-1:0]     out_digit,
  input logic [BYTES-1:0]     out_ctrl
);
  // R4: reset clears valid and data
  a_r4_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_planes == '0 && out_lt == '0 && out_gt == '0
             && out_digit == '0 && out_ctrl == '0));

  // R2: valid follows input one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R3: idle cycle drops valid and holds data
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_planes) && $stable(out_lt)
                   && $stable(out_gt) && $stable(out_digit) && $stable(out_ctrl)));

  for (genvar i = 0; i < BYTES; i++) begin : g_pos
    logic [7:0] byte_back;
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign byte_back[7-k] = out_planes[k*BYTES + i];
      // R1: each plane bit taps the right input bit
      a_r1_plane_tap: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_planes[k*BYTES + i] == $past(in_bytes[i*8 + 7 - k]));
    end
    // R5 .. R8: markers agree with the byte rebuilt from the planes
    a_r5_lt_match: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_lt[i] == (byte_back == 8'h3C));
    a_r6_gt_match: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_gt[i] == (byte_back == 8'h3E));
    a_r7_digit_match: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_digit[i] == (byte_back >= 8'h30 && byte_back <= 8'h39));
    a_r8_ctrl_match: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_ctrl[i] == (byte_back <= 8'h1F));
    // R9: at most one class per position
    a_r9_one_class: assert property (@(posedge clk) disable iff (rst)
      $onehot0({out_lt[i], out_gt[i], out_digit[i], out_ctrl[i]}));
  end
endmodule

bind byte_plane_classifier byte_plane_classifier_checker #(.BYTES(BYTES)) u_chk (.*);

// File: tb/byte_plane_classifier_test.sv
`timescale 1ns/1ps
module byte_plane_classifier_test;
  localparam int B = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [B*8-1:0] in_bytes = '0;
  logic out_valid;
  logic [8*B-1:0] out_planes;
  logic [B-1:0] out_lt, out_gt, out_digit, out_ctrl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  byte_plane_classifier #(.BYTES(B)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_planes(out_planes), .out_lt(out_lt),
    .out_gt(out_gt), .out_digit(out_digit), .out_ctrl(out_ctrl)
  );

  // byte value, then expected flags {ctrl, digit, gt, lt}
  localparam logic [11:0] TBL [14] = '{
    {8'h3C, 4'b0001}, {8'h3E, 4'b0010}, {8'h30, 4'b0100}, {8'h39, 4'b0100},
    {8'h3A, 4'b0000}, {8'h3D, 4'b0000}, {8'h2F, 4'b0000}, {8'h1F, 4'b1000},
    {8'h00, 4'b1000}, {8'h20, 4'b0000}, {8'h7F, 4'b0000}, {8'hBC, 4'b0000},
    {8'hFF, 4'b0000}, {8'h3F, 4'b0000}
  };

  function automatic logic [8*B-1:0] ref_planes(input logic [B*8-1:0] blk);
    logic [8*B-1:0] r;
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < B; i++)
        r[k*B + i] = blk[i*8 + 7 - k];
    return r;
  endfunction

  function automatic logic [B-1:0] ref_range(input logic [B*8-1:0] blk,
                                             input logic [7:0] lo, input logic [7:0] hi);
    logic [B-1:0] r;
    for (int i = 0; i < B; i++)
      r[i] = (blk[i*8 +: 8] >= lo) && (blk[i*8 +: 8] <= hi);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [8*B-1:0] act,
                     input logic [8*B-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_block(input logic [B*8-1:0] blk);
    logic [8*B-1:0] ep;
    logic [B-1:0] el, eg, ed, ec;
    ep = ref_planes(blk);
    el = ref_range(blk, 8'h3C, 8'h3C);
    eg = ref_range(blk, 8'h3E, 8'h3E);
    ed = ref_range(blk, 8'h30, 8'h39);
    ec = ref_range(blk, 8'h00, 8'h1F);
    chk(out_valid == 1'b1, "R2 valid", {127'b0, out_valid}, 128'd1);
    chk(out_planes == ep, "R1 planes", out_planes, ep);
    chk(out_lt == el, "R5 lt", {112'b0, out_lt}, {112'b0, el});
    chk(out_gt == eg, "R6 gt", {112'b0, out_gt}, {112'b0, eg});
    chk(out_digit == ed, "R7 digit", {112'b0, out_digit}, {112'b0, ed});
    chk(out_ctrl == ec, "R8 ctrl", {112'b0, out_ctrl}, {112'b0, ec});
  endtask

  // drive at a falling edge, load at the next rising edge, sample at the falling edge after
  task automatic load(input logic [B*8-1:0] blk);
    @(negedge clk);
    in_valid = 1'b1;
    in_bytes = blk;
    @(negedge clk);
    in_valid = 1'b0;
    in_bytes = ~blk;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [B*8-1:0] blk, held;
    logic [8*B-1:0] held_p;
    repeat (3) @(negedge clk);
    // R4: state after reset
    chk(out_valid == 1'b0 && out_planes == '0 && out_lt == '0 && out_gt == '0
        && out_digit == '0 && out_ctrl == '0, "R4 reset state",
        out_planes, '0);
    rst = 1'b0;

    // table walk: one byte value filling every position
    for (int t = 0; t < 14; t++) begin
      for (int i = 0; i < B; i++) blk[i*8 +: 8] = TBL[t][11:4];
      load(blk);
      chk(out_lt == {B{TBL[t][0]}}, "R5 table", {112'b0, out_lt}, {112'b0, {B{TBL[t][0]}}});
      chk(out_gt == {B{TBL[t][1]}}, "R6 table", {112'b0, out_gt}, {112'b0, {B{TBL[t][1]}}});
      chk(out_digit == {B{TBL[t][2]}}, "R7 table", {112'b0, out_digit}, {112'b0, {B{TBL[t][2]}}});
      chk(out_ctrl == {B{TBL[t][3]}}, "R8 table", {112'b0, out_ctrl}, {112'b0, {B{TBL[t][3]}}});
      check_block(blk);
    end

    // every byte value at every position group (R1, R5..R8)
    for (int g = 0; g < 256 / B; g++) begin
      for (int i = 0; i < B; i++) blk[i*8 +: 8] = 8'(g*B + i);
      load(blk);
      check_block(blk);
    end

    // R9: lone marker at first and last position, filler elsewhere
    blk = {B{8'h41}};
    blk[7:0] = 8'h3C;
    blk[B*8-1 -: 8] = 8'h3E;
    load(blk);
    chk(out_lt == B'(1), "R9 first position", {112'b0, out_lt}, 128'd1);
    chk(out_gt == (B'(1) << (B-1)), "R9 last position", {112'b0, out_gt},
        {112'b0, B'(1) << (B-1)});
    check_block(blk);

    // random blocks
    for (int n = 0; n < 200; n++) begin
      for (int w = 0; w < B/4; w++) blk[w*32 +: 32] = $urandom;
      load(blk);
      check_block(blk);
    end

    // R3: idle cycles with changing bytes keep outputs
    held = blk;
    held_p = ref_planes(held);
    @(negedge clk);
    in_bytes = {B{8'h3C}};
    @(negedge clk);
    in_bytes = {B{8'h05}};
    chk(out_valid == 1'b0, "R3 valid low", {127'b0, out_valid}, '0);
    chk(out_planes == held_p, "R3 planes held", out_planes, held_p);
    chk(out_lt == ref_range(held, 8'h3C, 8'h3C), "R3 lt held", {112'b0, out_lt},
        {112'b0, ref_range(held, 8'h3C, 8'h3C)});
    chk(out_ctrl == ref_range(held, 8'h00, 8'h1F), "R3 ctrl held", {112'b0, out_ctrl},
        {112'b0, ref_range(held, 8'h00, 8'h1F)});

    // R4: reset wins over a valid block
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_bytes = {B{8'h3C}};
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    chk(out_valid == 1'b0 && out_planes == '0 && out_lt == '0 && out_ctrl == '0,
        "R4 reset priority", out_planes, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule